// File: doc/BRIEF.md
# Framed-select SPI master (clock polarity 1, clock phase 1)

This block is an SPI master that sends 8-bit words from a small transmit queue and stores the returned words in a receive queue. SCLK rests high. Data leaves on the falling edges of SCLK and is captured on the rising edges, most significant bit first. Chip select is driven low once for a whole run of queued words. Software can load a multi-byte command, such as an address phase followed by dummy bytes, and the slave sees it as one transaction with a single select assertion.

The block starts a transaction when it is enabled and the transmit queue holds a word. Chip select stays low for as long as another word is already waiting when the current word finishes. Chip select rises only after the queue runs dry or the enable is withdrawn. It then stays high for a fixed minimum dwell before the next transaction can begin. The SCLK half period comes from a divider input, which is captured at the start of each transaction.

Top module: `spi_fm_master`

## Requirements
- R1: Whenever cs_n is high, sclk is high and mosi is low. This also holds in reset, where both queues read empty and tx_overflow is low.
- R2: A transaction starts, marked by cs_n falling, only while en is high and tx_empty is low. While en is low, queued words stay in the queue and cs_n stays high.
- R3: The first falling edge of sclk comes H system clocks after cs_n falls. That edge puts bit 7 of the first word on mosi.
- R4: Each word goes out MSB first on mosi. mosi changes on the falling edges of sclk. Each low or high level of sclk lasts exactly H system clocks.
- R5: After the last word of a transaction, cs_n rises 2·H system clocks (one full SCLK period) after the last rising edge of sclk.
- R6: If the transmit queue holds a word when the current word's final high level ends, the next word begins with a falling edge H clocks after the last rise. cs_n stays low, so one assertion frames the whole run of words.
- R7: After cs_n rises, and after reset, cs_n stays high for at least DWELL_CLKS system clocks before it falls again.
- R8: miso is sampled on each rising edge of sclk, MSB first. The completed word is pushed into the receive queue at its eighth rising edge. rx_data shows the oldest unread word, and rx_rd removes it.
- R9: Each queue holds FIFO_DEPTH (4) words and reports full and empty. A write while tx_full is high is dropped and sets tx_overflow, which stays high until reset.
- R10: If en drops during a transaction, the word in flight completes. cs_n is then released with the R5 timing, and the remaining words stay queued.
- R11: The half period H equals div, with div = 0 treated as 1. H is captured when cs_n falls, and changes to div during a transaction have no effect until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Allows transactions to start and to continue |
| div | input | DIV_W | SCLK half period in system clocks (0 acts as 1) |
| tx_wr | input | 1 | Write strobe for the transmit queue |
| tx_data | input | DATA_W | Word to queue for sending |
| tx_full | output | 1 | Transmit queue is full |
| tx_empty | output | 1 | Transmit queue is empty |
| tx_overflow | output | 1 | Sticky flag: a write arrived while the queue was full |
| rx_rd | input | 1 | Removes the oldest received word |
| rx_data | output | DATA_W | Oldest received word |
| rx_full | output | 1 | Receive queue is full |
| rx_empty | output | 1 | Receive queue is empty |
| sclk | output | 1 | Serial clock, high at rest |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is the continuation decision. It happens on the one system clock where a word's final high level ends. It needs a queued word to be present on that clock, and for a long frame it must recur over many words while the queue is being refilled. The stimulus preloads the queue and then runs a writer that tops it up whenever tx_full is low, while a reader drains the receive side at the same time. This produces a ten-word frame at a divider that is also changed mid-frame. Withdrawing en just after cs_n falls reaches the opposite outcome, where a word is waiting but the frame must still end.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  // Sequencer phases: select lead-in, two SCLK levels, release tail, dwell.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_DWELL
  } phase_e;

  // Effective SCLK half period in system clocks; zero is promoted to one.
  function automatic int unsigned eff_half(input int unsigned div_setting);
    return (div_setting == 0) ? 1 : div_setting;
  endfunction

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
  import spi_fm_pkg::*;
#(
  parameter int W          = 8,
  parameter int DIV_W      = 8,
  parameter int DWELL_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             tx_avail,
  input  logic [W-1:0]     tx_word,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [W-1:0]     rx_word,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n
);
  localparam int BW  = $clog2(W + 1);
  localparam int DWW = $clog2(DWELL_CLKS + 1);
  localparam int CW  = (DIV_W > DWW) ? DIV_W : DWW;

  phase_e           state;
  logic [CW-1:0]    cnt;
  logic [DIV_W-1:0] half_q, half_now;
  logic [BW-1:0]    bitcnt;
  logic [W-1:0]     tx_sh;
  logic [W-2:0]     rx_sh;

  // Named events shared with the checker and the outputs.
  logic cnt_zero, start_evt, word_end, chain_evt, rise_evt;

  assign half_now  = DIV_W'(eff_half(int'(div)));
  assign cnt_zero  = (cnt == '0);
  assign start_evt = (state == ST_IDLE) && en && tx_avail;
  assign word_end  = (state == ST_HIGH) && cnt_zero && (bitcnt == BW'(W));
  assign chain_evt = word_end && en && tx_avail;
  assign rise_evt  = (state == ST_LOW) && cnt_zero;
  assign tx_pop    = start_evt || chain_evt;
  assign rx_push   = rise_evt && (bitcnt == BW'(W - 1));
  assign rx_word   = {rx_sh, miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_DWELL;
      cnt    <= CW'(DWELL_CLKS - 1);
      half_q <= DIV_W'(1);
      bitcnt <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sclk   <= 1'b1;
      mosi   <= 1'b0;
      cs_n   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_evt) begin
            cs_n   <= 1'b0;
            half_q <= half_now;
            cnt    <= CW'(half_now - 1'b1);
            tx_sh  <= tx_word;
            bitcnt <= '0;
            state  <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (cnt_zero) begin
            sclk  <= 1'b0;
            mosi  <= tx_sh[W-1];
            tx_sh <= {tx_sh[W-2:0], 1'b0};
            cnt   <= CW'(half_q - 1'b1);
            state <= ST_LOW;
          end else cnt <= cnt - 1'b1;
        end
        ST_LOW: begin
          if (cnt_zero) begin
            sclk   <= 1'b1;
            rx_sh  <= {rx_sh[W-3:0], miso};
            bitcnt <= bitcnt + 1'b1;
            cnt    <= CW'(half_q - 1'b1);
            state  <= ST_HIGH;
          end else cnt <= cnt - 1'b1;
        end
        ST_HIGH: begin
          if (cnt_zero) begin
            cnt <= CW'(half_q - 1'b1);
            if (word_end) begin
              if (chain_evt) begin
                sclk   <= 1'b0;
                mosi   <= tx_word[W-1];
                tx_sh  <= {tx_word[W-2:0], 1'b0};
                bitcnt <= '0;
                state  <= ST_LOW;
              end else begin
                mosi  <= 1'b0;
                state <= ST_TAIL;
              end
            end else begin
              sclk  <= 1'b0;
              mosi  <= tx_sh[W-1];
              tx_sh <= {tx_sh[W-2:0], 1'b0};
              state <= ST_LOW;
            end
          end else cnt <= cnt - 1'b1;
        end
        ST_TAIL: begin
          if (cnt_zero) begin
            cs_n  <= 1'b1;
            cnt   <= CW'(DWELL_CLKS - 1);
            state <= ST_DWELL;
          end else cnt <= cnt - 1'b1;
        end
        ST_DWELL: begin
          if (cnt_zero) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_fm_master.sv
module spi_fm_master #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8,
  parameter int DWELL_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_overflow,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);
  logic              tx_pop_evt;
  logic              rx_push_evt;
  logic [DATA_W-1:0] tx_head, rx_word;
  logic              ovf_q;

  spi_fm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_data),
    .rd(tx_pop_evt), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spi_fm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .wr(rx_push_evt), .wdata(rx_word),
    .rd(rx_rd), .rdata(rx_data), .full(rx_full), .empty(rx_empty)
  );

  spi_fm_engine #(.W(DATA_W), .DIV_W(DIV_W), .DWELL_CLKS(DWELL_CLKS)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div),
    .tx_avail(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop_evt),
    .rx_push(rx_push_evt), .rx_word(rx_word), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  // Sticky record of a write that met a full transmit queue.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else if (tx_wr && tx_full) ovf_q <= 1'b1;
  end
  assign tx_overflow = ovf_q;
endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker #(
  parameter int DWELL_CLKS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic tx_wr,
  input logic tx_full,
  input logic tx_overflow,
  input logic rx_push_evt
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else if (!cs_n) hi_run <= '0;
    else if (hi_run != '1) hi_run <= hi_run + 1'b1;
  end

  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk && !mosi));

  p_first_fall_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (!cs_n && $past(!cs_n)));

  p_dwell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_run >= 16'(DWELL_CLKS)));

  p_push_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_evt |=> $rose(sclk));

  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full) |=> tx_overflow);

  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |=> tx_overflow);
endmodule

bind spi_fm_master spi_fm_checker #(.DWELL_CLKS(DWELL_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .tx_wr(tx_wr), .tx_full(tx_full), .tx_overflow(tx_overflow),
  .rx_push_evt(rx_push_evt)
);

// File: tb/spi_fm_master_test.sv
module spi_fm_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 4;
  localparam int DIVW  = 8;
  localparam int DWELL = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [DIVW-1:0] div = 8'd1;
  logic tx_wr = 1'b0, rx_rd = 1'b0, miso = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic tx_full, tx_empty, tx_overflow, rx_full, rx_empty, sclk, mosi, cs_n;
  logic [DW-1:0] rx_data;

  spi_fm_master #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .DIV_W(DIVW), .DWELL_CLKS(DWELL)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_overflow(tx_overflow),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_tx[$], exp_rx[$];
  int exp_frames[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic int eff_h(input int d);
    return (d == 0) ? 1 : d;
  endfunction
  function automatic logic [7:0] slave_byte(input int k);
    return 8'(k * 29 + 163);
  endfunction

  // Monitor and slave model, sampled at the falling clock edge.
  int cyc = 0, t_cs = 0, t_last = 0, bitn = 0, words = 0, sbit = 0, slave_k = 0;
  int hi_run = 0, idle_bad = 0, cs_falls = 0, cur_h = 1;
  bit first_fall = 0, released_once = 0, mon_on = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  logic [7:0] cap = '0;

  always @(negedge clk) begin
    logic [7:0] sb;
    cyc++;
    if (mon_on) begin
      if (cs_n && (!sclk || mosi)) idle_bad++;
      if (prev_cs && !cs_n) begin
        cs_falls++;
        if (released_once) check(hi_run >= DWELL, "R7", "cs_n high dwell", hi_run, DWELL);
        t_cs = cyc; first_fall = 1; words = 0; bitn = 0; sbit = 0;
      end
      if (!prev_cs && cs_n) begin
        check(cyc - t_last == 2 * cur_h, "R5", "last rise to cs_n rise", cyc - t_last, 2 * cur_h);
        if (exp_frames.size() > 0) begin
          int ef;
          ef = exp_frames.pop_front();
          check(words == ef, "R6", "words in one cs_n frame", words, ef);
        end
        released_once = 1;
        hi_run = 0;
      end
      if (cs_n) hi_run++; else hi_run = 0;
      if (prev_sclk && !sclk && !cs_n) begin
        if (first_fall) check(cyc - t_cs == cur_h, "R3", "cs_n fall to first sclk fall", cyc - t_cs, cur_h);
        else check(cyc - t_last == cur_h, "R4", "sclk high level length", cyc - t_last, cur_h);
        first_fall = 0;
        t_last = cyc;
        sb = slave_byte(slave_k);
        miso = sb[7 - sbit];
        sbit++;
      end
      if (!prev_sclk && sclk && !cs_n) begin
        check(cyc - t_last == cur_h, "R4", "sclk low level length", cyc - t_last, cur_h);
        t_last = cyc;
        cap = {cap[6:0], mosi};
        bitn++;
        if (bitn == 8) begin
          bitn = 0;
          words++;
          if (exp_tx.size() > 0) begin
            check(cap == exp_tx[0], "R4", "mosi word MSB first", cap, exp_tx[0]);
            void'(exp_tx.pop_front());
          end else check(0, "R4", "unexpected word on mosi", cap, -1);
          exp_rx.push_back(slave_byte(slave_k));
          slave_k++;
          sbit = 0;
        end
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // Write one word (called at a falling edge); returns to a falling edge.
  task automatic put_word(input logic [7:0] b, input bit accepted);
    tx_data = b; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    if (accepted) exp_tx.push_back(b);
  endtask

  task automatic preload(input int n);
    for (int i = 0; i < n; i++) put_word(8'($urandom), 1'b1);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!(tx_empty && cs_n));
  endtask

  task automatic drain_rx();
    while (!rx_empty) begin
      if (exp_rx.size() > 0) begin
        check(rx_data == exp_rx[0], "R8", "received word", rx_data, exp_rx[0]);
        void'(exp_rx.pop_front());
      end else check(0, "R8", "extra received word", rx_data, -1);
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      @(negedge clk);
    end
    check(exp_rx.size() == 0, "R8", "received word count left", exp_rx.size(), 0);
  endtask

  task automatic run_frame(input int d, input int n);
    en = 1'b0;
    div = 8'(d);
    cur_h = eff_h(d);
    preload(n);
    exp_frames.push_back(n);
    en = 1'b1;
    wait_done();
    en = 1'b0;
    drain_rx();
  endtask

  initial begin
    int falls0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b1 && mosi == 1'b0, "R1", "reset pin levels", {cs_n, sclk, mosi}, 3'b110);
    check(tx_empty && rx_empty && !tx_full, "R1", "reset queue flags", {tx_empty, rx_empty, tx_full}, 3'b110);
    check(tx_overflow == 1'b0, "R9", "reset overflow flag", tx_overflow, 0);
    rst_n = 1'b1;
    mon_on = 1;
    repeat (2) @(negedge clk);

    // R2: queued words wait while disabled.
    div = 8'd2; cur_h = 2;
    preload(2);
    falls0 = cs_falls;
    repeat (40) @(negedge clk);
    check(cs_falls == falls0 && cs_n == 1'b1, "R2", "no start while disabled", cs_falls - falls0, 0);
    check(tx_empty == 1'b0, "R2", "words held while disabled", tx_empty, 0);
    exp_frames.push_back(2);
    en = 1'b1;
    wait_done();
    en = 1'b0;
    check(tx_empty == 1'b1, "R2", "queue sent once enabled", tx_empty, 1);
    drain_rx();

    // R11: divider zero acts as one.
    run_frame(0, 1);

    // R9: overflow drops the fifth write and stays set.
    div = 8'd1; cur_h = 1;
    for (int i = 0; i < 5; i++) put_word(8'(8'h10 + i), i < DEPTH);
    check(tx_full == 1'b1, "R9", "tx_full after four writes", tx_full, 1);
    check(tx_overflow == 1'b1, "R9", "overflow after write to full", tx_overflow, 1);
    exp_frames.push_back(DEPTH);
    en = 1'b1;
    wait_done();
    en = 1'b0;
    drain_rx();
    check(tx_overflow == 1'b1, "R9", "overflow sticky", tx_overflow, 1);

    // R10: withdrawing enable mid-frame ends after the current word.
    div = 8'd1; cur_h = 1;
    preload(3);
    exp_frames.push_back(1);
    en = 1'b1;
    do @(negedge clk); while (cs_n);
    en = 1'b0;
    do @(negedge clk); while (!cs_n);
    check(tx_empty == 1'b0, "R10", "remaining words kept queued", tx_empty, 0);
    exp_frames.push_back(2);
    en = 1'b1;
    wait_done();
    en = 1'b0;
    drain_rx();

    // R6 and R11: long frame refilled on the fly, divider changed mid-frame.
    div = 8'd3; cur_h = 3;
    preload(4);
    exp_frames.push_back(10);
    en = 1'b1;
    fork
      begin
        int sent;
        sent = 4;
        do @(negedge clk); while (cs_n);
        div = 8'd1;
        while (sent < 10) begin
          if (!tx_full) begin
            put_word(8'($urandom), 1'b1);
            sent++;
          end else @(negedge clk);
        end
      end
      begin
        for (int r = 0; r < 10; r++) begin
          do begin @(negedge clk); #1; end while (rx_empty);
          if (exp_rx.size() > 0) begin
            check(rx_data == exp_rx[0], "R8", "streamed received word", rx_data, exp_rx[0]);
            void'(exp_rx.pop_front());
          end else check(0, "R8", "streamed word without expectation", rx_data, -1);
          rx_rd = 1'b1;
          @(negedge clk);
          rx_rd = 1'b0;
        end
      end
    join
    wait_done();
    en = 1'b0;
    drain_rx();

    // Constrained random frames.
    for (int it = 0; it < 8; it++) run_frame($urandom_range(0, 3), $urandom_range(1, DEPTH));

    repeat (10) @(negedge clk);
    check(idle_bad == 0, "R1", "idle cycles with wrong sclk or mosi", idle_bad, 0);
    check(exp_tx.size() == 0, "R4", "words never sent", exp_tx.size(), 0);
    check(exp_frames.size() == 0, "R6", "frames never closed", exp_frames.size(), 0);
    finish_run();
  end
endmodule